// File: doc/BRIEF.md
# Controller Output Port with Timed Low Pulse

This block holds the eight-bit output port of a keyboard controller. That port drives the system reset line, the A20 address gate and the keyboard clock and data outputs. Two of its bits are not stored. They show the live state of the output-buffer-full and input-buffer-empty flags. An outside command decoder gives the block single-cycle strobes: read the port, write the port from a parameter byte, or pulse some of its low four bits.

A pulse request carries a four-bit mask in which 0 selects a bit. Each selected bit is driven low for a fixed interval, `PULSE_CYC` clock cycles, which is 6 µs at the system clock rate. Afterwards the bit shows its stored value again. Pulsing bit 0 drops the reset line, which resets the CPU. A busy flag covers the whole interval, and new writes or pulses are refused while it is high.

Top module: `ctl_outport`

## Requirements
- R1: After reset the stored bits 7, 6, 3, 2 and 0 read 1, bit 1 equals parameter `A20_RST`, `busy` and `rsp_valid` are 0, and `sys_reset` is 0.
- R2: `port_q` bit 4 always equals `obf_in` and bit 5 always equals `ibe_in`, with no clock delay.
- R3: A `wr_req` accepted while idle loads `wr_data` bits 7, 6, 3, 2, 1 and 0 into the same `port_q` bits at the next clock edge; `wr_data` bits 5 and 4 have no effect.
- R4: A `rd_req` makes `rsp_valid` high for exactly the following cycle, with `rsp_data` equal to the `port_q` value of the request cycle.
- R5: A `pulse_req` accepted while idle with `pulse_mask` not equal to 4'hF drives every `port_q[i]` (i in 0..3) whose `pulse_mask[i]` is 0 to 0 from the next cycle on. When the pulse ends, those bits return to their stored values.
- R6: After an accepted pulse `busy` is high for exactly `PULSE_CYC` consecutive cycles, and the pulsed bits stay low for exactly those cycles.
- R7: During a pulse, low bits whose mask bit is 1 keep their stored values.
- R8: A `pulse_req` with `pulse_mask` = 4'hF changes nothing and leaves `busy` low.
- R9: `wr_req` and `pulse_req` that arrive while `busy` is high are ignored.
- R10: When `wr_req` and `pulse_req` arrive together while idle, the write is applied and the pulse is dropped.
- R11: `sys_reset` is the inverse of `port_q` bit 0 (high while the reset line is low), and `a20_gate` equals `port_q` bit 1.
- R12: A read taken during a pulse returns the pulsed (driven) port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| rd_req | input | 1 | Strobe: copy port into response |
| wr_req | input | 1 | Strobe: load port from `wr_data` |
| wr_data | input | 8 | Parameter byte for a port write |
| pulse_req | input | 1 | Strobe: pulse selected low bits |
| pulse_mask | input | 4 | Pulse selection, 0 = pulse this bit |
| obf_in | input | 1 | Output-buffer-full flag shown on bit 4 |
| ibe_in | input | 1 | Input-buffer-empty flag shown on bit 5 |
| port_q | output | 8 | Driven port value |
| sys_reset | output | 1 | CPU reset, high while bit 0 is low |
| a20_gate | output | 1 | A20 gate, bit 1 |
| busy | output | 1 | Pulse in progress |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |

## Verification
A stored bit that is corrupted shows on `port_q` in the same cycle it goes wrong, and it shows in the response byte one cycle after any read. A pulse timer that is off by even one count makes `busy` and the pulsed bits fall on the wrong edge. The bench counts every busy cycle of each pulse, so this cannot go unnoticed. A wrong selection latch shows on the first cycle of the pulse as the wrong bits going low. A broken busy gate lets a write through during a pulse, and this appears on bits 7 and 6 one cycle later.

// File: rtl/outport_pkg.sv
package outport_pkg;

  localparam int unsigned PORT_W   = 8;
  localparam int unsigned LOW_W    = 4;
  localparam int unsigned BIT_RST  = 0;
  localparam int unsigned BIT_A20  = 1;
  localparam int unsigned BIT_OBF  = 4;
  localparam int unsigned BIT_IBE  = 5;
  localparam int unsigned BIT_KCLK = 6;
  localparam int unsigned BIT_KDAT = 7;

  // Stored portion of the port; bits 4 and 5 are live mirrors.
  typedef struct packed {
    logic             kdat;
    logic             kclk;
    logic [LOW_W-1:0] low;
  } hold_t;

  function automatic hold_t hold_from_byte(input logic [PORT_W-1:0] b);
    hold_t h;
    h.kdat = b[BIT_KDAT];
    h.kclk = b[BIT_KCLK];
    h.low  = b[LOW_W-1:0];
    return h;
  endfunction

endpackage

// File: rtl/outport_rst_sync.sv
module outport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/outport_hold.sv
module outport_hold
  import outport_pkg::*;
#(
  parameter logic A20_RST = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  hold_t load_val,
  output hold_t q
);

  hold_t q_d;
  hold_t rst_val;

  always_comb begin
    rst_val      = '1;
    rst_val.low[BIT_A20] = A20_RST;
  end

  always_comb begin
    q_d = q;
    if (load_en) q_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= rst_val;
    else        q <= q_d;
  end

endmodule

// File: rtl/outport_pulse.sv
module outport_pulse
  import outport_pkg::*;
#(
  parameter int unsigned CYC = 300,
  localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOW_W-1:0] mask_n,
  output logic             busy,
  output logic [LOW_W-1:0] sel
);

  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_d;
  logic [LOW_W-1:0] sel_d;
  logic             go;

  assign go = start && !busy && (mask_n != '1);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    sel_d  = sel;
    if (go) begin
      busy_d = 1'b1;
      sel_d  = ~mask_n;
      cnt_d  = LAST;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        sel_d  = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      sel   <= '0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      sel   <= sel_d;
    end
  end

endmodule

// File: rtl/outport_rsp.sv
module outport_rsp
  import outport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [PORT_W-1:0] port_val,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_data
);

  logic [PORT_W-1:0] data_d;

  always_comb begin
    data_d = rsp_data;
    if (rd_req) data_d = port_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= data_d;
    end
  end

endmodule

// File: rtl/ctl_outport.sv
module ctl_outport
  import outport_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 300,
  parameter logic        A20_RST   = 1'b1,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              pulse_req,
  input  logic [LOW_W-1:0]  pulse_mask,
  input  logic              obf_in,
  input  logic              ibe_in,
  output logic [PORT_W-1:0] port_q,
  output logic              sys_reset,
  output logic              a20_gate,
  output logic              busy,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_data
);

  logic             rst_n_s;
  hold_t            hold_q;
  logic [LOW_W-1:0] pulse_sel;
  logic [LOW_W-1:0] low_eff;
  logic             wr_take;
  logic             pulse_take;
  logic [1:0]       unused_wr_bits;

  assign unused_wr_bits = wr_data[BIT_IBE:BIT_OBF];

  outport_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  // Write wins over a simultaneous pulse; both are refused while busy.
  assign wr_take    = wr_req && !busy;
  assign pulse_take = pulse_req && !busy && !wr_req;

  outport_hold #(.A20_RST(A20_RST)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_en  (wr_take),
    .load_val (hold_from_byte(wr_data)),
    .q        (hold_q)
  );

  outport_pulse #(.CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (pulse_take),
    .mask_n (pulse_mask),
    .busy   (busy),
    .sel    (pulse_sel)
  );

  generate
    for (genvar i = 0; i < LOW_W; i++) begin : g_low
      assign low_eff[i] = hold_q.low[i] && !(busy && pulse_sel[i]);
    end
  endgenerate

  always_comb begin
    port_q           = '0;
    port_q[LOW_W-1:0] = low_eff;
    port_q[BIT_OBF]  = obf_in;
    port_q[BIT_IBE]  = ibe_in;
    port_q[BIT_KCLK] = hold_q.kclk;
    port_q[BIT_KDAT] = hold_q.kdat;
  end

  assign sys_reset = !port_q[BIT_RST];
  assign a20_gate  = port_q[BIT_A20];

  outport_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_req    (rd_req),
    .port_val  (port_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/outport_chk.sv
module outport_chk #(
  parameter int unsigned CYC = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req,
  input logic       wr_req,
  input logic       pulse_req,
  input logic [3:0] pulse_mask,
  input logic [7:0] port_q,
  input logic       sys_reset,
  input logic       busy,
  input logic       rsp_valid,
  input logic [7:0] rsp_data
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid && (rsp_data == $past(port_q)));  // R4

  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);  // R4

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pulse_req && !wr_req && (pulse_mask != 4'hF)) |=>
      busy && ((port_q[3:0] & ~$past(pulse_mask)) == 4'h0)
      && ($past(pulse_mask[0]) || sys_reset));  // R5

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (run_q != 0)) |-> (run_q == CYC));  // R6

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < CYC));  // R6

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pulse_req && (pulse_mask == 4'hF)) |=> !busy);  // R8

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_req) |=> (port_q[7:6] == $past(port_q[7:6])));  // R9

  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_req && pulse_req) |=> !busy);  // R10

endmodule

bind ctl_outport outport_chk #(.CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .rd_req     (rd_req),
  .wr_req     (wr_req),
  .pulse_req  (pulse_req),
  .pulse_mask (pulse_mask),
  .port_q     (port_q),
  .sys_reset  (sys_reset),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data)
);

// File: tb/tb_ctl_outport.sv
module tb_ctl_outport;

  localparam int unsigned CYC = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req = 1'b0, wr_req = 1'b0, pulse_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] pulse_mask = 4'hF;
  logic       obf_in = 1'b0, ibe_in = 1'b1;
  logic [7:0] port_q, rsp_data;
  logic       sys_reset, a20_gate, busy, rsp_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctl_outport #(.PULSE_CYC(CYC), .A20_RST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .wr_data(wr_data), .pulse_req(pulse_req), .pulse_mask(pulse_mask),
    .obf_in(obf_in), .ibe_in(ibe_in), .port_q(port_q),
    .sys_reset(sys_reset), .a20_gate(a20_gate), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // {write byte, obf, ibe, expected port}
  localparam logic [17:0] VEC [6] = '{
    {8'h00, 1'b0, 1'b0, 8'h00},
    {8'hFF, 1'b0, 1'b0, 8'hCF},
    {8'h30, 1'b1, 1'b1, 8'h30},
    {8'hA5, 1'b1, 1'b0, 8'h95},
    {8'h5A, 1'b0, 1'b1, 8'h6A},
    {8'hC3, 1'b0, 1'b0, 8'hC3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R11 derived outputs, R2 mirrors
    check(port_q == 8'hEF, "R1 port", port_q, 8'hEF);
    check(!busy && !rsp_valid, "R1 busy/rsp", {busy, rsp_valid}, 0);
    check(!sys_reset && a20_gate, "R11 reset/a20", {sys_reset, a20_gate}, 2'b01);
    obf_in = 1'b1; ibe_in = 1'b0;
    #1 check(port_q == 8'hDF, "R2 mirror", port_q, 8'hDF);

    // R3 writes and R4 reads, table driven
    for (int i = 0; i < 6; i++) begin
      wr_data = VEC[i][17:10]; obf_in = VEC[i][9]; ibe_in = VEC[i][8];
      wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      check(port_q == VEC[i][7:0], "R3 write", port_q, VEC[i][7:0]);
      check(sys_reset == !VEC[i][0] && a20_gate == VEC[i][1], "R11 outputs",
            {sys_reset, a20_gate}, {!VEC[i][0], VEC[i][1]});
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      check(rsp_valid && rsp_data == VEC[i][7:0], "R4 read", rsp_data, VEC[i][7:0]);
      @(negedge clk);
      check(!rsp_valid, "R4 single", rsp_valid, 0);
    end

    // Pulse bits 0 and 2 with stored low nibble all ones
    obf_in = 1'b0; ibe_in = 1'b0;
    wr_data = 8'hCF; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    pulse_mask = 4'b1010; pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0; pulse_mask = 4'hF;
    check(busy && port_q[3:0] == 4'b1010, "R5 pulse low", port_q[3:0], 4'b1010);
    check(sys_reset, "R11 reset pulse", sys_reset, 1);
    n = 0;
    while (busy && n < 2 * CYC) begin
      n++;
      if (n == 10) begin
        wr_data = 8'h00; wr_req = 1'b1;
        pulse_mask = 4'h0; pulse_req = 1'b1;
      end else if (n == 11) begin
        wr_req = 1'b0; pulse_req = 1'b0; pulse_mask = 4'hF;
      end else if (n == 20) rd_req = 1'b1;
      else if (n == 21) begin
        rd_req = 1'b0;
        check(rsp_valid && rsp_data == 8'hCA, "R12 read in pulse", rsp_data, 8'hCA);
      end
      if (n == 50)
        check(port_q[3:0] == 4'b1010, "R7 unselected kept", port_q[3:0], 4'b1010);
      @(negedge clk);
    end
    check(n == CYC, "R6 pulse length", n, CYC);
    check(port_q == 8'hCF, "R9 write ignored / R5 restore", port_q, 8'hCF);
    @(negedge clk);
    check(!busy, "R9 pulse ignored", busy, 0);

    // R8 mask of all ones
    pulse_mask = 4'hF; pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0;
    check(!busy && port_q == 8'hCF, "R8 no-op mask", {busy, port_q}, 8'hCF);

    // R10 simultaneous write and pulse
    wr_data = 8'h4D; wr_req = 1'b1; pulse_mask = 4'h0; pulse_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; pulse_req = 1'b0; pulse_mask = 4'hF;
    check(!busy && port_q == 8'h4D, "R10 write wins", {busy, port_q}, 8'h4D);
    @(negedge clk);
    check(!busy, "R10 no late pulse", busy, 0);

    // R1 reset again during a pulse
    pulse_mask = 4'b1110; pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0; pulse_mask = 4'hF;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && port_q == 8'hCF, "R1 reset mid-pulse", {busy, port_q}, 8'hCF);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule